// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two predictors side by side and letting a table of 2-bit selection counters decide which one to trust. The global component holds 2-bit counters addressed by a shift register of recent outcomes from all branches. The local component has two levels. A per-branch history table, addressed by fetch address bits, records that branch's own recent outcomes. The selected history then addresses a table of 3-bit counters.

Lookup is purely combinational. The fetch stage presents a PC and reads back the final direction and both component directions in the same cycle. When a branch resolves, the pipeline presents the PC, the real outcome and the two component directions it saw at lookup. On that clock edge the block trains every table and shifts the outcome into both histories. Table sizes are parameters. The defaults are small so that simulation runs quickly; the full-size configuration (12-bit global history, 1024 x 10-bit local histories, 3-bit counters) totals 29K bits of state. Repairing speculatively updated history is not part of this block.

Top module: `tourn_pred`

## Requirements
- R1: After reset every counter and every history is zero, so every lookup returns local, global and final direction all not taken.
- R2: Global and chooser counters are 2 bits, saturate at 0 and 3, and a global counter predicts taken when its value is 2 or 3.
- R3: Local counters are 3 bits, saturate at 0 and 7, and predict taken when their value is 4 or more.
- R4: The global counter and the chooser counter are both addressed by the global history. An update shifts the outcome into bit 0 of the global history, where 1 means taken, and older outcomes move toward higher bits.
- R5: The local history entry is selected by `pc[2 +: LHT_IDX_W]`. That entry addresses the local counter table. An update trains the counter at the entry's current value and then shifts the outcome into bit 0 of the entry.
- R6: When the addressed chooser counter is 2 or 3, the final direction is the global direction; otherwise it is the local direction.
- R7: The chooser counter changes only when exactly one component prediction matched the outcome. It steps up when the global prediction was the correct one and steps down when the local prediction was the correct one.
- R8: When `upd_valid` is low, no table or history changes, whatever the other update inputs carry.
- R9: Lookup outputs depend on `lk_pc` and on the state left by the last update edge, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Final direction chosen by the chooser |
| pred_global | output | 1 | Global component direction |
| pred_local | output | 1 | Local component direction |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 means taken |
| upd_pred_global | input | 1 | Global direction given at lookup |
| upd_pred_local | input | 1 | Local direction given at lookup |

## Verification
The three lookup outputs are combinational, so they are due in the same cycle that `lk_pc` changes. An update becomes visible right after the rising edge on which `upd_valid` is high. The bench drives all inputs on the falling edge and samples the lookup one time unit later, with `upd_valid` held low during sampling. It then applies the update on the next rising edge and advances its own model of the tables at that edge. Each comparison therefore sees exactly the updates that came before it.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // saturating step of an unsigned counter in [0, maxv]
  function automatic int sat_step(int cur, logic up, int maxv);
    if (up)
      return (cur >= maxv) ? maxv : cur + 1;
    else
      return (cur <= 0) ? 0 : cur - 1;
  endfunction

  // history shift: newest outcome enters at bit 0
  function automatic int hist_push(int cur, logic bit_in, int width);
    int mask;
    mask = (1 << width) - 1;
    return ((cur << 1) | int'(bit_in)) & mask;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int W     = 2,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXV  = (1 << W) - 1;

  logic [DEPTH-1:0][W-1:0] mem;
  logic [W-1:0] wr_cur;
  logic [W-1:0] wr_nxt;

  // upper half of the range means taken
  assign rd_taken = mem[rd_idx][W-1];
  assign wr_cur   = mem[wr_idx];
  assign wr_nxt   = W'(tp_pkg::sat_step(int'(wr_cur), wr_up, MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n)
      mem <= '0;
    else if (wr_en)
      mem[wr_idx] <= wr_nxt;
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_up && (wr_cur == W'(MAXV)) |=> mem[$past(wr_idx)] == W'(MAXV)); // R2
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_up && (wr_cur == '0) |=> mem[$past(wr_idx)] == '0); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_up && (wr_cur != W'(MAXV)) |=> mem[$past(wr_idx)] == $past(wr_cur) + 1'b1); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem)); // R8

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W = 4,
  parameter int HW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [HW-1:0]    rd_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [HW-1:0]    wr_cur,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][HW-1:0] mem;

  assign rd_hist = mem[rd_idx];
  assign wr_cur  = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)
      mem <= '0;
    else if (wr_en)
      mem[wr_idx] <= HW'(tp_pkg::hist_push(int'(wr_cur), wr_bit, HW));
  end

  AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == {$past(wr_cur[HW-2:0]), $past(wr_bit)}); // R5
  AST_LHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem)); // R8

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 6,
  parameter int LHT_IDX_W = 4,
  parameter int LHIST_W   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_pred_global,
  input  logic            upd_pred_local
);
  localparam int GCTR_W = 2;
  localparam int LCTR_W = 3;
  localparam int CH_W   = 2;
  localparam int PC_LSB = 2;

  logic [GHIST_W-1:0]   ghist;
  logic [LHT_IDX_W-1:0] lk_lht_idx;
  logic [LHT_IDX_W-1:0] upd_lht_idx;
  logic [LHIST_W-1:0]   lk_lhist;
  logic [LHIST_W-1:0]   upd_lhist;
  logic                 use_global;

  // named events for assertions
  logic global_ok;
  logic local_ok;
  logic chooser_move;

  assign lk_lht_idx  = lk_pc[PC_LSB +: LHT_IDX_W];
  assign upd_lht_idx = upd_pc[PC_LSB +: LHT_IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_LSB+LHT_IDX_W], lk_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:PC_LSB+LHT_IDX_W], upd_pc[PC_LSB-1:0]};

  assign global_ok    = (upd_pred_global == upd_taken);
  assign local_ok     = (upd_pred_local == upd_taken);
  assign chooser_move = upd_valid && (global_ok != local_ok);

  tp_ctr_table #(.W(GCTR_W), .IDX_W(GHIST_W)) u_global (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_taken(pred_global),
    .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
  );

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HW(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lht_idx), .rd_hist(lk_lhist),
    .wr_en(upd_valid), .wr_idx(upd_lht_idx), .wr_cur(upd_lhist), .wr_bit(upd_taken)
  );

  tp_ctr_table #(.W(LCTR_W), .IDX_W(LHIST_W)) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lhist), .rd_taken(pred_local),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  // chooser: upper half selects global, steps toward the lone correct side
  tp_ctr_table #(.W(CH_W), .IDX_W(GHIST_W)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_taken(use_global),
    .wr_en(chooser_move), .wr_idx(ghist), .wr_up(global_ok)
  );

  assign pred_taken = use_global ? pred_global : pred_local;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ghist <= '0;
    else if (upd_valid)
      ghist <= GHIST_W'(tp_pkg::hist_push(int'(ghist), upd_taken, GHIST_W));
  end

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)}); // R4
  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist)); // R8
  AST_FINAL_FROM_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global == pred_local) |-> pred_taken == pred_global); // R6

endmodule

// File: tb/tourn_pred_bench.sv
`timescale 1ns/1ps
module tourn_pred_bench;
  localparam int PC_W = 32, GH = 6, LI = 4, LH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, upd_pred_global = 1'b0, upd_pred_local = 1'b0;
  logic pred_taken, pred_global, pred_local;

  always #5 clk = ~clk;

  tourn_pred #(.PC_W(PC_W), .GHIST_W(GH), .LHT_IDX_W(LI), .LHIST_W(LH)) u_tourn_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_pred_global(upd_pred_global), .upd_pred_local(upd_pred_local)
  );

  int n_chk = 0, n_fail = 0;
  int m_g[1<<GH];
  int m_c[1<<GH];
  int m_l[1<<LH];
  int m_h[1<<LI];
  int m_gh;
  bit e_g, e_l, e_t;

  function automatic int bump(int v, bit up, int top);
    int r;
    r = v;
    if (up && v < top) r = v + 1;
    if (!up && v > 0) r = v - 1;
    return r;
  endfunction

  function automatic int slot(logic [PC_W-1:0] pc);
    return int'((pc >> 2) % (1 << LI));
  endfunction

  task automatic model_predict(logic [PC_W-1:0] pc);
    e_g = m_g[m_gh] > 1;
    e_l = m_l[m_h[slot(pc)]] > 3;
    e_t = (m_c[m_gh] > 1) ? e_g : e_l;
  endtask

  task automatic model_update(logic [PC_W-1:0] pc, bit t, bit pg, bit pl);
    int s;
    s = slot(pc);
    m_g[m_gh] = bump(m_g[m_gh], t, 3);
    m_l[m_h[s]] = bump(m_l[m_h[s]], t, 7);
    if ((pg == t) && (pl != t)) m_c[m_gh] = bump(m_c[m_gh], 1'b1, 3);
    if ((pg != t) && (pl == t)) m_c[m_gh] = bump(m_c[m_gh], 1'b0, 3);
    m_h[s] = (m_h[s] * 2 + int'(t)) % (1 << LH);
    m_gh   = (m_gh * 2 + int'(t)) % (1 << GH);
  endtask

  task automatic check1(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample lookup, then update at posedge
  task automatic step(logic [PC_W-1:0] pc, bit v, bit t, bit corrupt);
    @(negedge clk);
    upd_valid = 1'b0;
    lk_pc = pc;
    #1;
    model_predict(pc);
    check1("R2 R4 pred_global", pred_global, e_g);
    check1("R3 R5 pred_local", pred_local, e_l);
    check1("R6 R7 R9 pred_taken", pred_taken, e_t);
    upd_pc = pc;
    upd_taken = t;
    upd_pred_global = corrupt ? 1'($urandom) : e_g;
    upd_pred_local  = corrupt ? 1'($urandom) : e_l;
    upd_valid = v;
    @(posedge clk);
    if (v) model_update(pc, t, upd_pred_global, upd_pred_local);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pcs[4];
    bit last0;
    int cnt0;
    void'($urandom(32'd1234));
    pcs[0] = 32'h100; pcs[1] = 32'h104; pcs[2] = 32'h140; pcs[3] = 32'h21c;
    foreach (m_g[i]) m_g[i] = 0;
    foreach (m_c[i]) m_c[i] = 0;
    foreach (m_l[i]) m_l[i] = 0;
    foreach (m_h[i]) m_h[i] = 0;
    m_gh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, several addresses
    for (int i = 0; i < 4; i++) begin
      lk_pc = pcs[i];
      #1;
      check1("R1 reset pred_global", pred_global, 1'b0);
      check1("R1 reset pred_local", pred_local, 1'b0);
      check1("R1 reset pred_taken", pred_taken, 1'b0);
    end
    // R2 R3 saturation: long runs of one outcome
    for (int i = 0; i < 14; i++) step(pcs[0], 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 14; i++) step(pcs[0], 1'b1, 1'b0, 1'b0);
    // R7: disagreeing component guesses both ways
    for (int i = 0; i < 20; i++) step(pcs[2], 1'b1, i[0], 1'b1);
    // R8: idle cycles with noisy update fields
    for (int i = 0; i < 10; i++) step(pcs[i % 4], 1'b0, 1'($urandom), 1'b1);
    // random mix
    last0 = 1'b0; cnt0 = 0;
    for (int i = 0; i < 4000; i++) begin
      int k;
      bit t;
      k = $urandom % 4;
      case (k)
        0: begin cnt0++; t = (cnt0 % 4) != 0; last0 = t; end
        1: t = ~last0;
        2: t = 1'($urandom);
        default: t = ($urandom % 8) != 0;
      endcase
      step(pcs[k], ($urandom % 6) != 0, t, ($urandom % 8) == 0);
    end
    step(pcs[1], 1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule